// File: doc/BRIEF.md
# DDR3 Refresh Burst Scheduler

This block sits beside the command arbiter of a DDR3 controller and decides when refresh must happen. Rather than one REFRESH per refresh interval, it groups refreshes into bursts of a fixed number of back-to-back commands. That stretches the time allowed between bursts to the burst size times the single-command interval, less the refresh-to-activate gaps spent inside the burst. A counter tracks controller clocks since the most recent REFRESH. When the count reaches the deadline less a configurable margin, the block raises a refresh request. The margin leaves the arbiter time to close all open rows first.

The arbiter accepts the request with a grant pulse. From then on the block reports a refresh in progress, and only REFRESH or NOOP commands may go to the memory. Each REFRESH that the arbiter places on the bus is reported back with a one-cycle pulse. After each pulse the block drops its request and re-raises it once the refresh-to-activate time has elapsed, until the whole burst has been issued. An activate-allowed flag stays low during the burst and for the refresh-to-activate time after its last command.

Top module: `refresh_burst_sched`

## Requirements
- R1: After reset, the request and the in-progress flag are low and the activate-allowed flag is high.
- R2: The allowed gap between bursts is BURST_LEN*REFI_CLKS-(BURST_LEN-1)*RFC_CLKS clocks. The request rises on the first clock on which the count of clocks since the last REFRESH reaches that gap minus MARGIN_CLKS. After reset that count starts at zero.
- R3: A grant sampled while the request is high and no burst is in progress sets the in-progress flag on the next clock. A grant sampled while the request is low has no effect on any output.
- R4: The activate-allowed flag is low during every clock on which the in-progress flag is high.
- R5: After each refresh pulse inside a burst, the request is low on the next clock. It rises again exactly RFC_CLKS clocks after the pulse was sampled, provided the burst is not yet complete.
- R6: A burst ends with its BURST_LEN-th refresh pulse, and the in-progress flag is low on the next clock. The next burst again needs BURST_LEN pulses, because a refresh that follows a completed burst restarts the count at one.
- R7: After the last refresh of a burst, the activate-allowed flag rises exactly RFC_CLKS clocks after that pulse was sampled.
- R8: Every refresh pulse restarts the clocks-since-refresh count. The next request therefore comes MARGIN_CLKS clocks before the gap of R2 expires, counted from the burst's last refresh.
- R9: A raised request stays high, with the in-progress flag unchanged, for as long as no refresh pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter accepts the refresh request (one-cycle pulse) |
| ref_issued | input | 1 | A REFRESH command was placed on the bus this clock |
| ref_req | output | 1 | Request for the next REFRESH of a burst |
| ref_busy | output | 1 | Refresh burst in progress; only REFRESH or NOOP may be sent |
| act_ok | output | 1 | An ACTIVATE may be issued |

## Verification
The assertions assume the arbiter is well behaved. It sends a refresh pulse only while the request is high and a burst has been granted, and it never sends two pulses on the same clock. The bench acts as that arbiter. It drives every pulse on the negative edge, one clock long, after it has seen the request high. The only other stimulus is a grant sent with no request pending, which the block must ignore.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  function automatic int unsigned burst_deadline(input int unsigned refi,
                                                 input int unsigned nburst,
                                                 input int unsigned rfc);
    return nburst * refi - (nburst - 1) * rfc;
  endfunction

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
  parameter int unsigned LIMIT = 5280,
  parameter int unsigned TRIG  = 5264,
  localparam int unsigned W    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic due
);
  logic [W-1:0] since_q, since_d;
  logic         en;

  always_comb begin
    en      = clr || (since_q != W'(LIMIT));
    since_d = clr ? '0 : since_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  since_q <= '0;
    else if (en) since_q <= since_d;
  end

  assign due = (since_q >= W'(TRIG));

  // R8: a refresh always restarts the interval
  a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (since_q == '0));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    since_q <= W'(LIMIT));
endmodule

// File: rtl/refsch_gap_timer.sv
module refsch_gap_timer #(
  parameter int unsigned LOAD = 320,
  localparam int unsigned W   = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  logic [W-1:0] left_q, left_d;
  logic         en;

  always_comb begin
    en     = load || (left_q != '0);
    left_d = load ? W'(LOAD) : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  left_q <= '0;
    else if (en) left_q <= left_d;
  end

  assign done = (left_q == '0);

  a_r5_gap_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);
endmodule

// File: rtl/refsch_burst_track.sv
module refsch_burst_track #(
  parameter int unsigned NBURST = 4,
  localparam int unsigned W     = $clog2(NBURST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic issue,
  output logic busy
);
  logic [W-1:0] num_q, num_d;
  logic         busy_q, busy_d;

  always_comb begin
    num_d  = num_q;
    busy_d = busy_q;
    if (issue) begin
      num_d = (num_q >= W'(NBURST)) ? W'(1) : num_q + 1'b1;
    end
    if (issue && (num_d == W'(NBURST))) busy_d = 1'b0;
    else if (take)                      busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= W'(NBURST);
      busy_q <= 1'b0;
    end else begin
      if (issue) num_q <= num_d;
      if (issue || take) busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (num_q >= W'(1)) && (num_q <= W'(NBURST)));
  a_r6_restart_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (num_q == W'(NBURST))) |=> (num_q == W'(1)));
endmodule

// File: rtl/refresh_burst_sched.sv
module refresh_burst_sched
  import refsch_pkg::*;
#(
  parameter int unsigned REFI_CLKS   = 1560,
  parameter int unsigned BURST_LEN   = 4,
  parameter int unsigned RFC_CLKS    = 320,
  parameter int unsigned MARGIN_CLKS = 16,
  localparam int unsigned DEADLINE   = burst_deadline(REFI_CLKS, BURST_LEN, RFC_CLKS),
  localparam int unsigned TRIGGER    = DEADLINE - MARGIN_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  input  logic ref_issued,
  output logic ref_req,
  output logic ref_busy,
  output logic act_ok
);
  logic due, gap_done, busy, take;

  refsch_interval_timer #(.LIMIT(DEADLINE), .TRIG(TRIGGER)) u_interval (
    .clk(clk), .rst_n(rst_n), .clr(ref_issued), .due(due));

  refsch_gap_timer #(.LOAD(RFC_CLKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(ref_issued), .done(gap_done));

  refsch_burst_track #(.NBURST(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .take(take), .issue(ref_issued), .busy(busy));

  always_comb begin
    take     = ref_grant && due && !busy;
    ref_req  = busy ? gap_done : due;
    ref_busy = busy;
    act_ok   = !busy && gap_done;
  end

  a_r4_no_act_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !act_ok);
  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issued |=> !ref_req);
  a_r7_act_blocked_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issued |=> !act_ok);
  a_r3_busy_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> $past(ref_grant));
  a_r6_end_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> $past(ref_issued));
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_issued && !ref_grant) |=> (ref_req && $stable(ref_busy)));
endmodule

// File: tb/test_refresh_burst_sched.sv
module test_refresh_burst_sched;
  localparam int REFI = 40, NB = 4, RFC = 10, MARGIN = 6;
  localparam int TRIG = NB * REFI - (NB - 1) * RFC - MARGIN;

  logic clk = 1'b0, rst_n = 1'b0, ref_grant = 1'b0, ref_issued = 1'b0;
  logic ref_req, ref_busy, act_ok;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  refresh_burst_sched #(.REFI_CLKS(REFI), .BURST_LEN(NB), .RFC_CLKS(RFC),
                        .MARGIN_CLKS(MARGIN)) i_refresh_burst_sched (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_issued(ref_issued),
    .ref_req(ref_req), .ref_busy(ref_busy), .act_ok(act_ok));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req && n < 1000);
  endtask

  task automatic wait_act(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!act_ok && n < 1000);
  endtask

  task automatic pulse_issue();
    ref_issued = 1'b1;
    @(negedge clk);
    ref_issued = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req", ref_req, 0);
    check("R1 busy", ref_busy, 0);
    check("R1 act_ok", act_ok, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_first_due();
    int n;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    check("R3 grant ignored busy", ref_busy, 0);
    check("R3 grant ignored act_ok", act_ok, 1);
    wait_req(n);
    check("R2 request time", n + 1, TRIG);
  endtask

  task automatic t_hold();
    repeat (20) @(negedge clk);
    check("R9 req held", ref_req, 1);
    check("R9 busy unchanged", ref_busy, 0);
  endtask

  task automatic t_burst(input string tag);
    int n;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    check({"R3 busy after grant ", tag}, ref_busy, 1);
    check({"R4 act_ok low ", tag}, act_ok, 0);
    check({"R5 req kept ", tag}, ref_req, 1);
    for (int k = 1; k <= NB; k++) begin
      pulse_issue();
      check({"R5 req drops ", tag}, ref_req, 0);
      if (k < NB) begin
        check({"R6 still busy ", tag}, ref_busy, 1);
        wait_req(n);
        check({"R5 gap ", tag}, n, RFC);
        check({"R4 act_ok in burst ", tag}, act_ok, 0);
      end
    end
    check({"R6 burst done ", tag}, ref_busy, 0);
    check({"R7 act blocked ", tag}, act_ok, 0);
    wait_act(n);
    check({"R7 act delay ", tag}, n, RFC);
    wait_req(n);
    check({"R8 next due ", tag}, n + RFC, TRIG);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_due();
        t_hold();
        t_burst("first");
        t_burst("second");
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule